// File: doc/BRIEF.md
# Multi-Port Register File with Per-Bit Write Masking

This block is a parameterised storage array with several write ports and several read ports. Every write port carries an active-low write enable, an address, a data word and an active-low per-bit mask. All of them are sampled on the rising edge of one common write clock. When two write ports name the same word in the same cycle, the bits are merged in port order. The higher-numbered port takes precedence on each bit that both ports unmask.

Every read port has its own clock, an active-low read enable, an address and an active-low output enable. On a read edge the port captures the addressed word into its output register. In read standby the register keeps its value. While the output enable is inactive, the data pins are released to high impedance, whatever the read enable is doing. The array contents are not reset. The output registers clear to zero under reset.

Top module: `regfile_mp_bw`

## Requirements
- R1: A write port whose enable is sampled high (write standby) leaves every stored word unchanged, whatever its address, data and mask are.
- R2: With the write enable sampled low, data bit i is stored only when mask bit i is 0. A stored bit whose mask bit is 1 keeps its previous value.
- R3: When several write ports hit one address in the same cycle, each bit takes the data of the highest-numbered port that unmasks it. A bit that no port unmasks keeps its old value.
- R4: A read port whose read enable is sampled high keeps its output register at its previous value.
- R5: With the output enable at 1, a port's data output is released (high impedance). With it at 0, the output shows the port's output register.
- R6: A read edge with read enable 0 loads the word stored at the sampled address into the output register. On an edge that also writes that address, the read returns the value stored before the write.
- R7: While reset is low, every read port's output register is zero.
- R8: Each read port runs on its own clock, and activity on one port does not disturb another port's held output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Common write clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read output registers |
| wr_en_n | input | NUM_WR | Active-low write enable, one bit per write port |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses; port p uses slice [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write data; port p uses slice [p*DATA_W +: DATA_W] |
| wr_mask_n | input | NUM_WR*DATA_W | Active-low per-bit write masks; bit 0 means write that bit |
| rd_clk | input | NUM_RD | Read clock, one bit per read port |
| rd_en_n | input | NUM_RD | Active-low read enable per read port |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses; port r uses slice [r*ADDR_W +: ADDR_W] |
| rd_oe_n | input | NUM_RD | Active-low output enable per read port |
| rd_data | output | NUM_RD*DATA_W | Read data; port r uses slice [r*DATA_W +: DATA_W], high impedance when disabled |

## Verification
The hardest case to reach is a same-cycle collision in which both write ports target one word with partly overlapping masks. The per-bit precedence can only be seen when the unmasked sets overlap and also differ. The stimulus therefore includes a directed collision with crossing masks. The random phase also draws addresses from a narrow window, so collisions and read-during-write on the shared edge occur often. A separate phase drives the second read port on its own, slower clock while the first port stays in standby, which exposes any coupling between the read domains.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_MAX_W = 256;

  // Keep bits whose mask is 1, take new data where mask is 0.
  function automatic logic [RF_MAX_W-1:0] rf_bit_merge(
    input logic [RF_MAX_W-1:0] old_word,
    input logic [RF_MAX_W-1:0] new_word,
    input logic [RF_MAX_W-1:0] keep_mask
  );
    return (old_word & keep_mask) | (new_word & ~keep_mask);
  endfunction
endpackage

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import rf_pkg::*;
#(
  parameter int NUM_WR = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] mem_q,
  input  logic [NUM_WR-1:0]            wr_en_n,
  input  logic [NUM_WR*ADDR_W-1:0]     wr_addr,
  input  logic [NUM_WR*DATA_W-1:0]     wr_data,
  input  logic [NUM_WR*DATA_W-1:0]     wr_mask_n,
  output logic [DEPTH-1:0][DATA_W-1:0] mem_d,
  output logic [NUM_WR-1:0]            wr_fire
);
  logic [RF_MAX_W-1:0] merged;
  logic [ADDR_W-1:0]   slot;

  assign wr_fire = ~wr_en_n;

  // Ports applied in ascending order: later ports override shared bits.
  always_comb begin
    mem_d  = mem_q;
    merged = '0;
    slot   = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      if (wr_fire[p]) begin
        slot   = wr_addr[p*ADDR_W +: ADDR_W];
        merged = rf_bit_merge(RF_MAX_W'(mem_d[slot]),
                              RF_MAX_W'(wr_data[p*DATA_W +: DATA_W]),
                              RF_MAX_W'(wr_mask_n[p*DATA_W +: DATA_W]));
        mem_d[slot] = merged[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                         clk,
  input  logic [NUM_WR-1:0]            wr_fire,
  input  logic [DEPTH-1:0][DATA_W-1:0] mem_d,
  input  logic [NUM_RD*ADDR_W-1:0]     rd_addr,
  output logic [DEPTH-1:0][DATA_W-1:0] mem_q,
  output logic [NUM_RD*DATA_W-1:0]     rd_word
);
  // No reset on the array contents.
  always_ff @(posedge clk) begin
    if (|wr_fire) mem_q <= mem_d;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd_mux
    assign rd_word[r*DATA_W +: DATA_W] = mem_q[rd_addr[r*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] q_o,
  output logic              fire_o,
  output logic [DATA_W-1:0] data_o
);
  assign fire_o = ~en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (fire_o) q_o <= word_i;
  end

  assign data_o = oe_n ? {DATA_W{1'bz}} : q_o;
endmodule

// File: rtl/regfile_mp_bw.sv
module regfile_mp_bw #(
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                     wr_clk,
  input  logic                     rst_n,
  input  logic [NUM_WR-1:0]        wr_en_n,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  logic [NUM_WR*DATA_W-1:0] wr_mask_n,
  input  logic [NUM_RD-1:0]        rd_clk,
  input  logic [NUM_RD-1:0]        rd_en_n,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
  input  logic [NUM_RD-1:0]        rd_oe_n,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0][DATA_W-1:0] mem_d;
  logic [NUM_WR-1:0]            wr_fire;
  logic [NUM_RD*DATA_W-1:0]     rd_word;
  logic [NUM_RD*DATA_W-1:0]     rd_q;
  logic [NUM_RD-1:0]            rd_fire;

  rf_write_merge #(.NUM_WR(NUM_WR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_merge (
    .mem_q(mem_q), .wr_en_n(wr_en_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask_n(wr_mask_n), .mem_d(mem_d), .wr_fire(wr_fire)
  );

  rf_storage #(.NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(wr_clk), .wr_fire(wr_fire), .mem_d(mem_d), .rd_addr(rd_addr),
    .mem_q(mem_q), .rd_word(rd_word)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    rf_read_port #(.DATA_W(DATA_W)) u_port (
      .clk(rd_clk[r]), .rst_n(rst_n), .en_n(rd_en_n[r]), .oe_n(rd_oe_n[r]),
      .word_i(rd_word[r*DATA_W +: DATA_W]), .q_o(rd_q[r*DATA_W +: DATA_W]),
      .fire_o(rd_fire[r]), .data_o(rd_data[r*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic                         wr_clk,
  input logic                         rst_n,
  input logic [NUM_RD-1:0]            rd_clk,
  input logic [NUM_WR-1:0]            wr_fire,
  input logic [DEPTH-1:0][DATA_W-1:0] mem_q,
  input logic [NUM_RD-1:0]            rd_en_n,
  input logic [NUM_RD-1:0]            rd_oe_n,
  input logic [NUM_RD*DATA_W-1:0]     rd_word,
  input logic [NUM_RD*DATA_W-1:0]     rd_q,
  input logic [NUM_RD*DATA_W-1:0]     rd_data
);
  a_r1_standby_keeps_array: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_fire == '0) |=> $stable(mem_q));

  for (genvar r = 0; r < NUM_RD; r++) begin : g_chk
    a_r4_standby_holds: assert property (@(posedge rd_clk[r]) disable iff (!rst_n)
      rd_en_n[r] |=> $stable(rd_q[r*DATA_W +: DATA_W]));

    a_r6_read_loads_word: assert property (@(posedge rd_clk[r]) disable iff (!rst_n)
      !rd_en_n[r] |=> (rd_q[r*DATA_W +: DATA_W] == $past(rd_word[r*DATA_W +: DATA_W])));

    a_r5_drives_when_enabled: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !rd_oe_n[r] |-> (rd_data[r*DATA_W +: DATA_W] == rd_q[r*DATA_W +: DATA_W]));
  end
endmodule

bind regfile_mp_bw rf_checker #(
  .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .wr_clk(wr_clk), .rst_n(rst_n), .rd_clk(rd_clk), .wr_fire(wr_fire),
  .mem_q(mem_q), .rd_en_n(rd_en_n), .rd_oe_n(rd_oe_n), .rd_word(rd_word),
  .rd_q(rd_q), .rd_data(rd_data)
);

// File: tb/tb_regfile_mp_bw.sv
module tb_regfile_mp_bw;
  localparam int CLK_PERIOD = 10;
  localparam int RD1_PERIOD = 14;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int NW = 2;
  localparam int NR = 2;

  logic              wr_clk = 1'b0, rd_clk1 = 1'b0, rst_n = 1'b1;
  logic [NW-1:0]     wr_en_n = '1;
  logic [NW*AW-1:0]  wr_addr = '0;
  logic [NW*DW-1:0]  wr_data = '0, wr_mask_n = '1;
  logic [NR-1:0]     rd_clk, rd_en_n = '1, rd_oe_n = '0;
  logic [NR*AW-1:0]  rd_addr = '0;
  wire  [NR*DW-1:0]  rd_data;

  assign rd_clk = {rd_clk1, wr_clk};

  regfile_mp_bw #(.NUM_WR(NW), .NUM_RD(NR), .ADDR_W(AW), .DATA_W(DW)) dut (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask_n(wr_mask_n), .rd_clk(rd_clk), .rd_en_n(rd_en_n),
    .rd_addr(rd_addr), .rd_oe_n(rd_oe_n), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD1_PERIOD/2) rd_clk1 = ~rd_clk1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp0 = '0, exp1 = '0;

  // staged stimulus for one shared-clock cycle
  logic s_en0 = 1, s_en1 = 1, s_ren = 1, s_oe = 0;
  logic [AW-1:0] s_a0 = 0, s_a1 = 0, s_ra = 0;
  logic [DW-1:0] s_d0 = 0, s_d1 = 0, s_m0 = '1, s_m1 = '1;

  function automatic logic [DW-1:0] ref_merge(logic [DW-1:0] old_v, logic [DW-1:0] d,
                                              logic [DW-1:0] keep);
    logic [DW-1:0] res = old_v;
    for (int i = 0; i < DW; i++) if (keep[i] == 1'b0) res[i] = d[i];
    return res;
  endfunction

  task automatic cmp(logic [DW-1:0] act, logic [DW-1:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R5: released output reads as z (a two-state model may resolve it to 0)
  task automatic cmp_released(logic [DW-1:0] act, string tag);
    n_chk++;
    if (!(act === {DW{1'bz}} || act === '0)) begin
      n_bad++;
      $display("FAIL %s: actual %h expected zzzz", tag, act);
    end
  endtask

  task automatic go0(string tag);
    @(negedge wr_clk);
    wr_en_n   = {s_en1, s_en0};
    wr_addr   = {s_a1, s_a0};
    wr_data   = {s_d1, s_d0};
    wr_mask_n = {s_m1, s_m0};
    rd_en_n[0] = s_ren; rd_addr[AW-1:0] = s_ra; rd_oe_n[0] = s_oe;
    if (!s_ren) exp0 = ref_mem[s_ra];        // read sees value before this edge's writes
    if (!s_en0) ref_mem[s_a0] = ref_merge(ref_mem[s_a0], s_d0, s_m0);
    if (!s_en1) ref_mem[s_a1] = ref_merge(ref_mem[s_a1], s_d1, s_m1);
    @(posedge wr_clk); #1;
    if (s_oe) cmp_released(rd_data[DW-1:0], "R5 port0 released");
    else      cmp(rd_data[DW-1:0], exp0, tag);
    cmp(rd_data[2*DW-1:DW], exp1, "R4 port1 held during writes");
  endtask

  task automatic go1(logic ren, logic [AW-1:0] ra, logic oe);
    @(negedge rd_clk1);
    rd_en_n[1] = ren; rd_addr[2*AW-1:AW] = ra; rd_oe_n[1] = oe;
    if (!ren) exp1 = ref_mem[ra];
    @(posedge rd_clk1); #1;
    if (oe) cmp_released(rd_data[2*DW-1:DW], "R5 port1 released");
    else    cmp(rd_data[2*DW-1:DW], exp1, ren ? "R4 port1 standby" : "R8 port1 read");
    cmp(rd_data[DW-1:0], exp0, "R8 port0 undisturbed");
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    #2 rst_n = 0;
    repeat (3) @(posedge wr_clk);
    #1;
    cmp(rd_data[DW-1:0], '0, "R7 port0 reset");
    cmp(rd_data[2*DW-1:DW], '0, "R7 port1 reset");
    @(negedge wr_clk) rst_n = 1;

    // fill every word through port 0 with all bits unmasked
    for (int a = 0; a < (1 << AW); a++) begin
      s_en0 = 0; s_a0 = AW'(a); s_d0 = DW'($urandom); s_m0 = '0;
      s_en1 = 1; s_ren = 1; s_oe = 0;
      go0("R4 port0 standby during fill");
    end
    s_en0 = 1;

    // R1: standby write with an open mask changes nothing
    s_a0 = 3; s_d0 = ~ref_mem[3]; s_m0 = '0; go0("R1 standby issue");
    s_ren = 0; s_ra = 3; go0("R1 word unchanged after standby write");

    // R2: partial mask
    s_ren = 1; s_en0 = 0; s_a0 = 5; s_d0 = 16'hFFFF; s_m0 = 16'hF0F0; go0("R2 masked write");
    s_en0 = 1; s_ren = 0; s_ra = 5; go0("R2 only unmasked bits stored");

    // R3: collision with overlapping masks
    s_ren = 1; s_en0 = 0; s_en1 = 0; s_a0 = 7; s_a1 = 7;
    s_d0 = 16'hAAAA; s_m0 = 16'h00FF; s_d1 = 16'h5555; s_m1 = 16'h0FF0;
    go0("R3 collision issue");
    s_en0 = 1; s_en1 = 1; s_ren = 0; s_ra = 7; go0("R3 higher port wins shared bits");

    // R6: read and write one word on the same edge
    s_en0 = 0; s_a0 = 9; s_d0 = ~ref_mem[9]; s_m0 = '0; s_ra = 9;
    go0("R6 read-before-write returns old");
    s_en0 = 1; go0("R6 new value visible next read");

    // R5: output disable then re-enable
    s_oe = 1; s_ren = 1; go0("R5 disabled");
    s_oe = 0; go0("R5 re-enabled shows register");

    // random mix, narrow address window to force collisions
    for (int k = 0; k < 400; k++) begin
      logic narrow;
      narrow = ($urandom % 2) == 0;
      s_en0 = ($urandom % 10) < 3; s_en1 = ($urandom % 10) < 4;
      s_a0 = narrow ? AW'($urandom % 4) : AW'($urandom);
      s_a1 = narrow ? AW'($urandom % 4) : AW'($urandom);
      s_ra = narrow ? AW'($urandom % 4) : AW'($urandom);
      s_d0 = DW'($urandom); s_d1 = DW'($urandom);
      s_m0 = DW'($urandom); s_m1 = DW'($urandom);
      s_ren = ($urandom % 4) == 0; s_oe = ($urandom % 8) == 0;
      go0(s_ren ? "R4 port0 standby" : "R6 port0 read");
    end

    // port 1 on its own clock, port 0 held in standby
    s_en0 = 1; s_en1 = 1; s_ren = 1; s_oe = 0;
    go0("R4 port0 standby before port1 phase");
    for (int k = 0; k < 80; k++)
      go1(($urandom % 4) == 0, AW'($urandom), ($urandom % 8) == 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule